// File: doc/BRIEF.md
# Sequential 32x32 Multiplier with Condition Codes

This block multiplies two 32-bit operands into a 64-bit product, treating them either as unsigned numbers or as two's complement numbers according to a mode input sampled with the start strobe. A single 16x16 unsigned multiplier is reused over four cycles. Each cycle it forms one partial product from one half of each operand magnitude and adds it, at the right weight, into a 64-bit accumulator. A final cycle applies the result sign and computes the condition codes.

Signed operands are first reduced to magnitudes. The result sign is the exclusive-or of the two operand signs, and a negative product is produced by inverting all 64 bits and adding one. When either operand is zero, no partial product is computed and the zero result comes back one cycle after the start strobe. The caller supplies its current condition codes. The extend bit passes through to the output, and the other four bits are recomputed from the product.

Top module: `mpy_seq_flags`

## Requirements
- R1: In unsigned mode (`is_signed`=0), `{prod_hi, prod_lo}` equals the 64-bit unsigned product of `opa` and `opb`.
- R2: In signed mode (`is_signed`=1), `{prod_hi, prod_lo}` equals the 64-bit two's complement product of `opa` and `opb`, including the operand value 0x80000000.
- R3: If either operand is zero when a start is accepted, `done` is high in the cycle after the capturing edge, the product is zero, and the flags show Z=1, N=0, V=0, C=0.
- R4: For two nonzero operands, `done` goes high five clock edges after the edge that captures `start`.
- R5: The flag vector is laid out as bit 4 = X, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. On every result, X equals bit 4 of `ccr_in` as sampled with `start`, and V and C are 0.
- R6: N equals bit 63 of the product in both modes. Z is 1 only when all 64 product bits are zero.
- R7: A `start` that arrives while `busy` is high is ignored. It produces no result and does not disturb the operation in progress.
- R8: `done` is a single-cycle pulse per accepted start. Between pulses, `prod_hi`, `prod_lo` and `ccr_out` hold the last result.
- R9: While reset is asserted, `prod_hi`, `prod_lo`, `ccr_out`, `done` and `busy` are all zero.
- R10: For nonzero operands, `busy` is high from the cycle after the capturing edge until `done` rises, and it is never high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| ccr_in | input | 5 | Incoming flags {X,N,Z,V,C} |
| prod_hi | output | 32 | Upper word of the product |
| prod_lo | output | 32 | Lower word of the product |
| ccr_out | output | 5 | Resulting flags {X,N,Z,V,C} |
| done | output | 1 | One-cycle pulse when a result is presented |
| busy | output | 1 | Partial-product or sign-fix cycles in progress |

## Verification
The assertions check the following on every cycle:
- the flag invariants: N against bit 63, V and C cleared, and X carried on the zero path;
- the zero short-cut result;
- the fixed five-edge latency of the multiply path;
- the mutual exclusion of `busy` and `done`;
- output stability between results.

Product values need the bench's scoreboard. It restates the product with a full-width reference multiply and checks unsigned and signed corners such as all-ones operands, 0x80000000 squared and carries that cross the 32-bit boundary. It also checks that a start arriving mid-operation leaves the queued result untouched.

// File: rtl/mpy_pkg.sv
package mpy_pkg;

  localparam int MPY_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PP   = 2'd1,
    ST_FIX  = 2'd2
  } mpy_state_e;

  // flag vector, x in bit 4 down to c in bit 0
  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // absolute value of an operand when signed mode applies
  function automatic logic [MPY_W-1:0] op_magnitude(input logic [MPY_W-1:0] val,
                                                    input logic          sgn_mode);
    logic [MPY_W-1:0] r;
    if (sgn_mode && val[MPY_W-1]) r = ~val + 1'b1;
    else                          r = val;
    return r;
  endfunction

  // full-width two's complement: invert and add one with carry
  function automatic logic [2*MPY_W-1:0] wide_negate(input logic [2*MPY_W-1:0] val);
    return ~val + {{(2*MPY_W-1){1'b0}}, 1'b1};
  endfunction

  // flags for a finished product
  function automatic ccr_t flags_for(input logic x_keep, input logic [2*MPY_W-1:0] prod);
    ccr_t f;
    f.x = x_keep;
    f.n = prod[2*MPY_W-1];
    f.z = (prod == '0);
    f.v = 1'b0;
    f.c = 1'b0;
    return f;
  endfunction

endpackage

// File: rtl/mpy_operand_prep.sv
module mpy_operand_prep #(
  parameter int OP_W = mpy_pkg::MPY_W
) (
  input  logic [OP_W-1:0] opa,
  input  logic [OP_W-1:0] opb,
  input  logic            is_signed,
  output logic [OP_W-1:0] mag_a,
  output logic [OP_W-1:0] mag_b,
  output logic            neg_result,
  output logic            has_zero
);
  import mpy_pkg::*;

  logic sign_a;
  logic sign_b;

  always_comb begin
    sign_a     = is_signed & opa[OP_W-1];
    sign_b     = is_signed & opb[OP_W-1];
    mag_a      = op_magnitude(opa, is_signed);
    mag_b      = op_magnitude(opb, is_signed);
    neg_result = sign_a ^ sign_b;
    has_zero   = (opa == '0) || (opb == '0);
  end

endmodule

// File: rtl/mpy_pp_accum.sv
module mpy_pp_accum #(
  parameter int OP_W = mpy_pkg::MPY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [1:0]        step_idx,
  input  logic [OP_W-1:0]   mag_a,
  input  logic [OP_W-1:0]   mag_b,
  output logic [2*OP_W-1:0] acc
);
  localparam int HALF  = OP_W / 2;
  localparam int ACC_W = 2 * OP_W;

  logic [HALF-1:0]  half_a;
  logic [HALF-1:0]  half_b;
  logic [OP_W-1:0]  pp;
  logic [1:0]       weight;
  logic [ACC_W-1:0] pp_wide;
  logic [ACC_W-1:0] pp_aligned;

  // idx bit 0 picks the upper half of a, bit 1 the upper half of b
  assign half_a = step_idx[0] ? mag_a[OP_W-1:HALF] : mag_a[HALF-1:0];
  assign half_b = step_idx[1] ? mag_b[OP_W-1:HALF] : mag_b[HALF-1:0];

  assign pp      = {{HALF{1'b0}}, half_a} * {{HALF{1'b0}}, half_b};
  assign pp_wide = {{OP_W{1'b0}}, pp};
  assign weight  = {1'b0, step_idx[0]} + {1'b0, step_idx[1]};

  always_comb begin
    case (weight)
      2'd0:    pp_aligned = pp_wide;
      2'd1:    pp_aligned = pp_wide << HALF;
      default: pp_aligned = pp_wide << OP_W;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (step)  acc <= acc + pp_aligned;
  end

endmodule

// File: rtl/mpy_result_fix.sv
module mpy_result_fix #(
  parameter int OP_W = mpy_pkg::MPY_W
) (
  input  logic [2*OP_W-1:0] acc,
  input  logic              neg_result,
  input  logic              x_keep,
  output logic [2*OP_W-1:0] product,
  output mpy_pkg::ccr_t     ccr
);
  import mpy_pkg::*;

  always_comb begin
    product = neg_result ? wide_negate(acc) : acc;
    ccr     = flags_for(x_keep, product);
  end

endmodule

// File: rtl/mpy_seq_flags.sv
module mpy_seq_flags #(
  parameter int OP_W = mpy_pkg::MPY_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_signed,
  input  logic [OP_W-1:0] opa,
  input  logic [OP_W-1:0] opb,
  input  logic [4:0]      ccr_in,
  output logic [OP_W-1:0] prod_hi,
  output logic [OP_W-1:0] prod_lo,
  output logic [4:0]      ccr_out,
  output logic            done,
  output logic            busy
);
  import mpy_pkg::*;

  localparam int ACC_W  = 2 * OP_W;
  localparam int NUM_PP = 4;

  mpy_state_e       state;
  logic [1:0]       pp_idx;
  logic [OP_W-1:0]  mag_a_q;
  logic [OP_W-1:0]  mag_b_q;
  logic             neg_q;
  logic             x_q;
  logic [ACC_W-1:0] prod_q;
  ccr_t             ccr_q;
  logic             done_q;

  logic [OP_W-1:0]  mag_a_c;
  logic [OP_W-1:0]  mag_b_c;
  logic             neg_c;
  logic             zero_c;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] fixed_prod;
  ccr_t             fixed_ccr;
  ccr_t             cin;
  logic             unused_cin_bits;

  // named events for the checker
  logic accept;
  logic zero_hit;
  logic mul_launch;
  logic pp_step;
  logic fix_step;
  logic last_pp;

  assign cin             = ccr_t'(ccr_in);
  assign unused_cin_bits = ^{cin.n, cin.z, cin.v, cin.c};

  assign accept     = start && (state == ST_IDLE);
  assign zero_hit   = accept && zero_c;
  assign mul_launch = accept && !zero_c;
  assign pp_step    = (state == ST_PP);
  assign fix_step   = (state == ST_FIX);
  assign last_pp    = pp_step && (pp_idx == 2'(NUM_PP - 1));

  mpy_operand_prep #(.OP_W(OP_W)) prep_i (
    .opa        (opa),
    .opb        (opb),
    .is_signed  (is_signed),
    .mag_a      (mag_a_c),
    .mag_b      (mag_b_c),
    .neg_result (neg_c),
    .has_zero   (zero_c)
  );

  mpy_pp_accum #(.OP_W(OP_W)) accum_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (mul_launch),
    .step     (pp_step),
    .step_idx (pp_idx),
    .mag_a    (mag_a_q),
    .mag_b    (mag_b_q),
    .acc      (acc)
  );

  mpy_result_fix #(.OP_W(OP_W)) fix_i (
    .acc        (acc),
    .neg_result (neg_q),
    .x_keep     (x_q),
    .product    (fixed_prod),
    .ccr        (fixed_ccr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pp_idx  <= '0;
      mag_a_q <= '0;
      mag_b_q <= '0;
      neg_q   <= 1'b0;
      x_q     <= 1'b0;
      prod_q  <= '0;
      ccr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (zero_hit) begin
            prod_q <= '0;
            ccr_q  <= '{x: cin.x, n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
            done_q <= 1'b1;
          end else if (mul_launch) begin
            mag_a_q <= mag_a_c;
            mag_b_q <= mag_b_c;
            neg_q   <= neg_c;
            x_q     <= cin.x;
            pp_idx  <= '0;
            state   <= ST_PP;
          end
        end
        ST_PP: begin
          pp_idx <= pp_idx + 2'd1;
          if (last_pp) state <= ST_FIX;
        end
        ST_FIX: begin
          prod_q <= fixed_prod;
          ccr_q  <= fixed_ccr;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign prod_hi = prod_q[ACC_W-1:OP_W];
  assign prod_lo = prod_q[OP_W-1:0];
  assign ccr_out = ccr_q;
  assign done    = done_q;
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/mpy_seq_flags_chk.sv
module mpy_seq_flags_chk #(
  parameter int OP_W = mpy_pkg::MPY_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic [OP_W-1:0] prod_hi,
  input logic [OP_W-1:0] prod_lo,
  input logic [4:0]      ccr_out,
  input logic [4:0]      ccr_in,
  input logic            zero_hit,
  input logic            mul_launch,
  input logic            fix_step
);
  logic [2:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n)           lat <= '0;
    else if (mul_launch)  lat <= 3'd1;
    else if (lat == 3'd5) lat <= '0;
    else if (lat != 3'd0) lat <= lat + 3'd1;
  end

  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> done && ({prod_hi, prod_lo} == '0) && (ccr_out[3:0] == 4'b0100)); // R3

  AST_ZERO_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> ccr_out[4] == $past(ccr_in[4])); // R5

  AST_VC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ccr_out[1:0] == 2'b00); // R5

  AST_N_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ccr_out[3] == prod_hi[OP_W-1]); // R6

  AST_FIVE_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == 3'd5) |=> done); // R4

  AST_FIX_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fix_step |=> done); // R4

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mul_launch |=> busy); // R10

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({prod_hi, prod_lo, ccr_out})); // R8

endmodule

bind mpy_seq_flags mpy_seq_flags_chk #(.OP_W(OP_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .prod_hi    (prod_hi),
  .prod_lo    (prod_lo),
  .ccr_out    (ccr_out),
  .ccr_in     (ccr_in),
  .zero_hit   (zero_hit),
  .mul_launch (mul_launch),
  .fix_step   (fix_step)
);

// File: tb/mpy_seq_flags_tb_top.sv
module mpy_seq_flags_tb_top;
  localparam int CLK_PERIOD_NS = 10;

  typedef struct {
    logic [63:0] prod;
    logic [4:0]  ccr;
    int          due_cyc;
    string       rq_prod;
    string       rq_lat;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [4:0]  ccr_in = '0;
  logic [31:0] prod_hi;
  logic [31:0] prod_lo;
  logic [4:0]  ccr_out;
  logic        done;
  logic        busy;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  exp_item_t sb_q[$];
  logic [63:0] last_prod = '0;
  logic [4:0]  last_ccr = '0;

  always #(CLK_PERIOD_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mpy_seq_flags dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .opa(opa), .opb(opb), .ccr_in(ccr_in),
    .prod_hi(prod_hi), .prod_lo(prod_lo), .ccr_out(ccr_out),
    .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // reference product and flags written from the requirements
  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                           input logic sgn);
    logic signed [63:0] sa;
    logic signed [63:0] sb;
    if (sgn) begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      return 64'(sa * sb);
    end
    return {32'd0, a} * {32'd0, b};
  endfunction

  function automatic logic [4:0] ref_ccr(input logic xin, input logic [63:0] p);
    return {xin, p[63], (p == 64'd0), 2'b00};
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sgn,
                       input logic [4:0] cin);
    exp_item_t it;
    bit zero_op;
    @(negedge clk);
    while (busy) @(negedge clk);
    zero_op    = (a == 0) || (b == 0);
    it.prod    = ref_prod(a, b, sgn);
    it.ccr     = ref_ccr(cin[4], it.prod);
    it.due_cyc = cyc + (zero_op ? 1 : 6);
    it.rq_prod = sgn ? "R2" : "R1";
    it.rq_lat  = zero_op ? "R3" : "R4";
    sb_q.push_back(it);
    opa = a; opb = b; is_signed = sgn; ccr_in = cin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!zero_op) check(busy == 1'b1, "R10", "busy after launch", 64'(busy), 64'd1);
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7", "unexpected done", {prod_hi, prod_lo}, 64'd0);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        check({prod_hi, prod_lo} == it.prod, it.rq_prod, "product",
              {prod_hi, prod_lo}, it.prod);
        check(ccr_out == it.ccr, "R5/R6", "flags", 64'(ccr_out), 64'(it.ccr));
        check(cyc == it.due_cyc, it.rq_lat, "done cycle", 64'(cyc), 64'(it.due_cyc));
        check(busy == 1'b0, "R10", "busy with done", 64'(busy), 64'd0);
        last_prod = it.prod;
        last_ccr  = it.ccr;
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while (sb_q.size() != 0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    // R9 reset state
    check({prod_hi, prod_lo} == 64'd0, "R9", "product in reset", {prod_hi, prod_lo}, 64'd0);
    check({ccr_out, done, busy} == 7'd0, "R9", "flags/done/busy in reset",
          64'({ccr_out, done, busy}), 64'd0);
    rst_n = 1'b1;

    // R1 unsigned patterns, R6 N on bit 63
    issue(32'd3, 32'd5, 1'b0, 5'h00);
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'h00);
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 5'h10);
    issue(32'h0001_0000, 32'h0001_0000, 1'b0, 5'h0F);
    // R2 signed patterns, including the most negative value
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 5'h00);
    issue(32'hFFFF_FFFB, 32'd7, 1'b1, 5'h1F);
    issue(32'h8000_0000, 32'h8000_0000, 1'b1, 5'h00);
    issue(32'h8000_0000, 32'd1, 1'b1, 5'h10);
    // R3 zero short cut, R5 X kept
    issue(32'd0, 32'hDEAD_BEEF, 1'b0, 5'h1F);
    issue(32'hCAFE_0001, 32'd0, 1'b1, 5'h0F);
    issue(32'd0, 32'd0, 1'b1, 5'h10);
    drain();

    // R8 hold between pulses
    repeat (3) @(negedge clk);
    check({prod_hi, prod_lo} == last_prod, "R8", "product held", {prod_hi, prod_lo}, last_prod);
    check(ccr_out == last_ccr, "R8", "flags held", 64'(ccr_out), 64'(last_ccr));

    // R7 start while busy is ignored
    issue(32'h0000_BEEF, 32'h0001_2345, 1'b0, 5'h00);
    opa = 32'd0; opb = 32'h7777_7777; is_signed = 1'b1; ccr_in = 5'h1F; start = 1'b1;
    @(negedge clk);
    opa = 32'h5555_5555;
    @(negedge clk);
    start = 1'b0;
    drain();

    // mixed patterns from a simple generator
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 10; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      b = lcg;
      issue(a, b, i[0], {i[1], 4'b0101});
    end
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule